// File: doc/BRIEF.md
# Per-Master Address Aperture Decoder

This block decodes the addresses issued by several interconnect masters. Each master has its own register group. The group divides the 32-bit address space into sixteen 256 MB apertures, selected by the top address nibble. For every aperture the group names a target slave and supplies a replacement top nibble for the outgoing address. Each master's request address is decoded combinationally into three results: a slave code, a translated address and a decode-error flag.

Software writes the tables through a plain 32-bit register port. These writes land in a shadow copy and do not change routing. A separate commit write to the master's update register copies the whole shadow copy into the live decode in one clock. Master 0 also has a boot register. While that register is nonzero, requests in aperture 0 are steered to ROM. A separate address-extension register, with its own commit register, drives a live output.

Top module: `apt_decoder`

## Requirements
- R1: After reset, every live select field is 0 and every offset field i holds i. Shadow and live copies are equal. The master 0 boot field reads BOOT_RST (default 1). The extension output is 0.
- R2: Master m's group sits at register address 0x20*m. Select apertures 0-7 are at +0x00, select apertures 8-15 at +0x04, offset apertures 0-7 at +0x08 and offset apertures 8-15 at +0x0C. Reads return the shadow values.
- R3: A write to a select or offset register changes no decode output until that master's update is written.
- R4: A write to +0x14 with bit 0 set copies all four shadow registers into the live decode. The new decode is visible after that clock edge. A write to +0x14 with bit 0 clear has no effect.
- R5: The aperture index is address bits [31:28]. Aperture i uses field bits [4i+3:4i] of the low register (i<8) or bits [4(i-8)+3:4(i-8)] of the high register.
- R6: The translated address is {offset field of the aperture, request address [27:0]}.
- R7: Select codes 1 to 10 route to that slave with the error flag low. Codes 0 and 11 to 15 give a slave output of 0 and raise the error flag.
- R8: An update write to one master leaves the decode of every other master unchanged.
- R9: Master 0's boot register is at +0x10 and takes effect at once. While its bits [1:0] are nonzero, aperture 0 of master 0 routes to ROM (code 5), with no error and the address unchanged. In any other group, +0x10 reads 0 and writes to it are ignored.
- R10: The extension shadow register is at 0x180 and its update register is at 0x194. The output follows the shadow value only after a write of 1 to 0x194.
- R11: A write to an unmapped register address changes no register, and a read from one returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | RA_W | Register byte address, shared by reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| req_addr_i | input | N_MST x 32 | Request address, one per master |
| slv_sel_o | output | N_MST x 4 | Selected slave code, one per master |
| xlat_addr_o | output | N_MST x 32 | Translated address, one per master |
| dec_err_o | output | N_MST | Decode error, one per master |
| pae_o | output | PAE_W | Live address-extension value |

## Verification
A corrupted live table shows up on the same cycle as a wrong slave code, a wrong top address nibble or a wrong error flag. The fault only appears for requests that fall in the affected aperture. For that reason every aperture of one master is walked with distinct codes and distinct offsets. A wrongly timed copy from shadow to live shows as a decode change before the commit write, or as no change in the cycle after it. A missed commit stays hidden until a request reaches a reprogrammed aperture, so decodes are checked both between the shadow write and the commit and after the commit.

// File: rtl/apt_pkg.sv
package apt_pkg;
  localparam int unsigned NUM_APT = 16;
  localparam int unsigned FLD_W   = 4;
  localparam int unsigned TBL_W   = NUM_APT * FLD_W;

  typedef enum logic [3:0] {
    SLV_NONE   = 4'd0,
    SLV_MEM1   = 4'd1,
    SLV_SRAM   = 4'd2,
    SLV_TUNNEL = 4'd3,
    SLV_EXTBUS = 4'd4,
    SLV_ROM    = 4'd5,
    SLV_PERIPH = 4'd6,
    SLV_MEM2   = 4'd7,
    SLV_MEM3   = 4'd8,
    SLV_COHER  = 4'd9,
    SLV_DMI    = 4'd10
  } slv_code_e;

  localparam logic [3:0] SLV_LAST = SLV_DMI;

  localparam logic [4:0] OFS_SEL_LO = 5'h00;
  localparam logic [4:0] OFS_SEL_HI = 5'h04;
  localparam logic [4:0] OFS_OFT_LO = 5'h08;
  localparam logic [4:0] OFS_OFT_HI = 5'h0C;
  localparam logic [4:0] OFS_BOOT   = 5'h10;
  localparam logic [4:0] OFS_UPDATE = 5'h14;

  typedef struct packed {
    logic [TBL_W-1:0] sel;
    logic [TBL_W-1:0] oft;
  } apt_map_t;

  function automatic logic [TBL_W-1:0] ident_oft();
    logic [TBL_W-1:0] v;
    for (int i = 0; i < NUM_APT; i++) v[i*FLD_W +: FLD_W] = FLD_W'(i);
    return v;
  endfunction
endpackage

// File: rtl/apt_master_regs.sv
module apt_master_regs
  import apt_pkg::*;
#(
  parameter bit         HAS_BOOT = 1'b0,
  parameter logic [1:0] BOOT_RST = 2'b01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [4:0]  off_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output apt_map_t    live_o,
  output logic        mirror_o
);
  apt_map_t   shadow_q, live_q;
  logic [1:0] boot_q;
  logic       upd;

  assign upd = wr_i && (off_i == OFS_UPDATE) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q.sel <= '0;
      shadow_q.oft <= ident_oft();
      live_q.sel   <= '0;
      live_q.oft   <= ident_oft();
    end else begin
      if (wr_i) begin
        case (off_i)
          OFS_SEL_LO: shadow_q.sel[31:0]  <= wdata_i;
          OFS_SEL_HI: shadow_q.sel[63:32] <= wdata_i;
          OFS_OFT_LO: shadow_q.oft[31:0]  <= wdata_i;
          OFS_OFT_HI: shadow_q.oft[63:32] <= wdata_i;
          default: ;
        endcase
      end
      if (upd) live_q <= shadow_q;
    end
  end

  generate
    if (HAS_BOOT) begin : g_boot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             boot_q <= BOOT_RST;
        else if (wr_i && off_i == OFS_BOOT)      boot_q <= wdata_i[1:0];
      end
    end else begin : g_noboot
      assign boot_q = 2'b00;
    end
  endgenerate

  assign mirror_o = |boot_q;
  assign live_o   = live_q;

  always_comb begin
    case (off_i)
      OFS_SEL_LO: rdata_o = shadow_q.sel[31:0];
      OFS_SEL_HI: rdata_o = shadow_q.sel[63:32];
      OFS_OFT_LO: rdata_o = shadow_q.oft[31:0];
      OFS_OFT_HI: rdata_o = shadow_q.oft[63:32];
      OFS_BOOT:   rdata_o = {30'd0, boot_q};
      default:    rdata_o = '0;
    endcase
  end

  // R4: commit lands whole, one clock after the update write
  a_r4_commit_whole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> live_q == $past(shadow_q));
  // R3: without a commit the live decode holds
  a_r3_live_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(live_q));
endmodule

// File: rtl/apt_lookup.sv
module apt_lookup
  import apt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] addr_i,
  input  apt_map_t    map_i,
  input  logic        mirror_i,
  output logic [3:0]  sel_o,
  output logic        err_o,
  output logic [31:0] xaddr_o
);
  logic [3:0] idx, code, nib;
  logic       ok;

  assign idx  = addr_i[31:28];
  assign code = map_i.sel[{idx, 2'b00} +: FLD_W];
  assign nib  = map_i.oft[{idx, 2'b00} +: FLD_W];
  assign ok   = (code != SLV_NONE) && (code <= SLV_LAST);

  always_comb begin
    if (mirror_i && idx == 4'd0) begin
      sel_o   = SLV_ROM;
      err_o   = 1'b0;
      xaddr_o = addr_i;
    end else begin
      sel_o   = ok ? code : SLV_NONE;
      err_o   = !ok;
      xaddr_o = {nib, addr_i[27:0]};
    end
  end

  // R6: low 28 bits always pass through
  a_r6_low_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xaddr_o[27:0] == addr_i[27:0]);
  // R7: error flag and slave code never disagree
  a_r7_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == (sel_o == SLV_NONE));
endmodule

// File: rtl/apt_decoder.sv
module apt_decoder
  import apt_pkg::*;
#(
  parameter int unsigned N_MST    = 4,
  parameter int unsigned RA_W     = 12,
  parameter int unsigned PAE_W    = 8,
  parameter logic [1:0]  BOOT_RST = 2'b01,
  parameter int unsigned PAE_ADDR = 'h180,
  parameter int unsigned PAE_UPD  = 'h194
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [RA_W-1:0]       reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  input  logic [N_MST-1:0][31:0] req_addr_i,
  output logic [N_MST-1:0][3:0]  slv_sel_o,
  output logic [N_MST-1:0][31:0] xlat_addr_o,
  output logic [N_MST-1:0]       dec_err_o,
  output logic [PAE_W-1:0]       pae_o
);
  localparam int unsigned GRP_W = RA_W - 5;

  logic [GRP_W-1:0]              grp;
  logic [4:0]                    off;
  logic [N_MST-1:0]              hit;
  logic [N_MST-1:0][31:0]        grp_rdata;
  logic [N_MST-1:0]              mirror;
  apt_map_t                      live [N_MST];
  logic [PAE_W-1:0]              pae_sh_q, pae_q;
  logic                          pae_wr, pae_upd;

  assign grp = reg_addr_i[RA_W-1:5];
  assign off = reg_addr_i[4:0];

  generate
    for (genvar m = 0; m < N_MST; m++) begin : g_mst
      assign hit[m] = (grp == GRP_W'(m));

      apt_master_regs #(
        .HAS_BOOT (m == 0),
        .BOOT_RST (BOOT_RST)
      ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (reg_we_i && hit[m]),
        .off_i    (off),
        .wdata_i  (reg_wdata_i),
        .rdata_o  (grp_rdata[m]),
        .live_o   (live[m]),
        .mirror_o (mirror[m])
      );

      apt_lookup u_lkp (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .addr_i   (req_addr_i[m]),
        .map_i    (live[m]),
        .mirror_i (mirror[m]),
        .sel_o    (slv_sel_o[m]),
        .err_o    (dec_err_o[m]),
        .xaddr_o  (xlat_addr_o[m])
      );

      // R9: boot override forces ROM on aperture 0
      a_r9_mirror_rom: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mirror[m] && req_addr_i[m][31:28] == 4'd0) |->
          (slv_sel_o[m] == SLV_ROM && xlat_addr_o[m] == req_addr_i[m]));
    end
  endgenerate

  assign pae_wr  = reg_we_i && (reg_addr_i == RA_W'(PAE_ADDR));
  assign pae_upd = reg_we_i && (reg_addr_i == RA_W'(PAE_UPD)) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pae_sh_q <= '0;
      pae_q    <= '0;
    end else begin
      if (pae_wr)  pae_sh_q <= reg_wdata_i[PAE_W-1:0];
      if (pae_upd) pae_q    <= pae_sh_q;
    end
  end
  assign pae_o = pae_q;

  always_comb begin
    reg_rdata_o = '0;
    for (int m = 0; m < N_MST; m++)
      if (hit[m]) reg_rdata_o = grp_rdata[m];
    if (reg_addr_i == RA_W'(PAE_ADDR)) reg_rdata_o = 32'(pae_sh_q);
  end

  // R10: extension output moves only on its own commit
  a_r10_pae_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pae_upd |=> $stable(pae_o));
endmodule

// File: tb/sim_apt_decoder.sv
module sim_apt_decoder;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic we = 0;
  logic [11:0] ra = '0;
  logic [31:0] wd = '0, rd;
  logic [N-1:0][31:0] req = '0;
  logic [N-1:0][3:0]  sel;
  logic [N-1:0][31:0] xa;
  logic [N-1:0]       err;
  logic [7:0]         pae;
  int nvec = 0, nerr = 0;

  always #10 clk = ~clk;

  apt_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .req_addr_i(req),
    .slv_sel_o(sel), .xlat_addr_o(xa), .dec_err_o(err), .pae_o(pae)
  );

  // {master, addr, sel, err, xaddr} for master 1 after its commit
  localparam logic [70:0] VEC [12] = '{
    {2'd1, 32'h0123_4567, 4'd4,  1'b0, 32'h7123_4567},
    {2'd1, 32'h1FFF_FFFF, 4'd5,  1'b0, 32'h6FFF_FFFF},
    {2'd1, 32'h2000_0000, 4'd6,  1'b0, 32'h5000_0000},
    {2'd1, 32'h6ABC_DEF0, 4'd10, 1'b0, 32'h1ABC_DEF0},
    {2'd1, 32'h7000_0010, 4'd0,  1'b1, 32'h0000_0010},
    {2'd1, 32'h8000_0000, 4'd1,  1'b0, 32'hF000_0000},
    {2'd1, 32'hC555_5555, 4'd2,  1'b0, 32'hB555_5555},
    {2'd1, 32'hD000_0004, 4'd3,  1'b0, 32'hA000_0004},
    {2'd1, 32'hE000_0000, 4'd0,  1'b1, 32'h9000_0000},
    {2'd1, 32'hF0FF_FFFF, 4'd0,  1'b1, 32'h80FF_FFFF},
    {2'd2, 32'h5000_0000, 4'd0,  1'b1, 32'h5000_0000},
    {2'd3, 32'hB000_0000, 4'd0,  1'b1, 32'hB000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); ra = a; wd = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    ra = a; #1; chk(tag, rd, exp);
  endtask

  task automatic dec(input string tag, input int m, input logic [31:0] a,
                     input logic [3:0] s, input logic e, input logic [31:0] x);
    req[m] = a; #1;
    chk({tag, " sel"}, 32'(sel[m]), 32'(s));
    chk({tag, " err"}, 32'(err[m]), 32'(e));
    chk({tag, " xaddr"}, xa[m], x);
  endtask

  initial begin
    #4_000_000;
    nerr++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    dec("R1 m1 reset", 1, 32'h3000_0000, 4'd0, 1'b1, 32'h3000_0000);
    dec("R1 R9 m0 mirror at reset", 0, 32'h0000_1234, 4'd5, 1'b0, 32'h0000_1234);
    rdchk("R1 m1 oft lo", 12'h028, 32'h7654_3210);
    rdchk("R1 m1 oft hi", 12'h02C, 32'hFEDC_BA98);
    rdchk("R1 m0 boot", 12'h010, 32'h1);
    chk("R1 pae", 32'(pae), 32'h0);

    // program master 1 shadow
    wr(12'h020, 32'h0A98_7654);
    wr(12'h024, 32'hFB32_1111);
    wr(12'h028, 32'h0123_4567);
    wr(12'h02C, 32'h89AB_CDEF);
    rdchk("R2 m1 sel lo", 12'h020, 32'h0A98_7654);
    rdchk("R2 m1 sel hi", 12'h024, 32'hFB32_1111);
    rdchk("R2 m1 oft hi", 12'h02C, 32'h89AB_CDEF);
    dec("R3 pre-commit", 1, 32'h0123_4567, 4'd0, 1'b1, 32'h0123_4567);
    wr(12'h034, 32'h0);
    dec("R4 zero update ignored", 1, 32'h0123_4567, 4'd0, 1'b1, 32'h0123_4567);
    wr(12'h034, 32'h1);

    // R5 R6 R7 R8 vector walk
    for (int i = 0; i < 12; i++) begin
      dec($sformatf("R5 R6 R7 R8 vec%0d", i), int'(VEC[i][70:69]), VEC[i][68:37],
          VEC[i][36:33], VEC[i][32], VEC[i][31:0]);
    end

    // R4 whole commit on master 2: only sel lo changed, offsets stay identity
    wr(12'h040, 32'h0000_0090);
    wr(12'h054, 32'h1);
    dec("R4 m2 ap1", 2, 32'h1000_0000, 4'd9, 1'b0, 32'h1000_0000);
    dec("R8 m1 kept", 1, 32'h8000_0000, 4'd1, 1'b0, 32'hF000_0000);

    // R9 boot mirror
    wr(12'h000, 32'h0000_0007);
    wr(12'h014, 32'h1);
    dec("R9 m0 mirrored", 0, 32'h0800_0000, 4'd5, 1'b0, 32'h0800_0000);
    wr(12'h010, 32'h0);
    dec("R9 m0 mirror off", 0, 32'h0800_0000, 4'd7, 1'b0, 32'h0800_0000);
    rdchk("R9 m0 boot cleared", 12'h010, 32'h0);
    wr(12'h030, 32'h3);
    rdchk("R9 m1 no boot", 12'h030, 32'h0);
    dec("R9 m1 ap0 unmirrored", 1, 32'h0000_0100, 4'd4, 1'b0, 32'h7000_0100);

    // R10 extension register
    wr(12'h180, 32'h0000_005A);
    chk("R10 pae before commit", 32'(pae), 32'h0);
    rdchk("R10 pae shadow", 12'h180, 32'h5A);
    wr(12'h194, 32'h1);
    chk("R10 pae after commit", 32'(pae), 32'h5A);

    // R11 unmapped
    wr(12'h0C0, 32'hDEAD_BEEF);
    rdchk("R11 unmapped read", 12'h0C0, 32'h0);
    wr(12'h038, 32'hFFFF_FFFF);
    rdchk("R11 m1 hole", 12'h038, 32'h0);
    rdchk("R11 m1 sel lo intact", 12'h020, 32'h0A98_7654);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule